// File: doc/BRIEF.md
# Result Broadcast Bus Arbiter

This block sits between a group of result producers (arithmetic units and load buffers) and a single shared result bus. The producers finish out of order and may all be ready at once, but the bus can carry only one result per cycle. The arbiter picks one producer each cycle, and in the next cycle drives the bus with that producer's 64-bit result and the tag of the station that produced it. Every consumer waiting on a result, and the register status logic, watches the bus in that same cycle and takes the data whose tag it expects.

A producer raises its request with its data and its tag and keeps all three stable until it sees its grant. The grant is combinational, so a producer learns in the same cycle that it has won and may drop its request at the next edge. The bus register loads at that edge. In the cycle its result is on the bus, the winner's station is also flagged free. Losing producers simply keep waiting. The choice is round-robin, so a busy producer cannot shut out the others. Tag zero means "no producer" and is never put on the bus as a valid result. Reset is asynchronous and active low, and is expected to be released in step with the clock.

Top module: `rbus_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `bus_valid` is 0, `bus_tag` is 0 and `slot_free` is all zero.
- R2: At most one bit of `req_grant` is 1 in any cycle.
- R3: A grant goes only to a producer whose `req_valid` bit is 1 and whose tag field (bits `i*4 +: 4` of `req_tag`) is not zero. A request with tag zero is never granted and never reaches the bus.
- R4: In the cycle after producer i is granted, `bus_valid` is 1, `bus_data` equals producer i's data field (bits `i*64 +: 64` of `req_data`), and `bus_tag` equals its tag field.
- R5: In the cycle after a cycle with no grant, `bus_valid` is 0.
- R6: `slot_free` in each cycle equals `req_grant` of the cycle before. The freed station's bit is set in the same cycle its result is on the bus.
- R7: Priority is round-robin. After producer i wins, the search for the next winner starts at producer i+1 and wraps from N_REQ-1 to 0. After reset the search starts at producer 0.
- R8: If any producer meets the conditions of R3, some producer is granted in that cycle.
- R9: While `bus_valid` is 0, `bus_data` and `bus_tag` keep their last values.
- R10: Whenever `bus_valid` is 1, `bus_tag` is not zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | N_REQ | One request bit per producer |
| req_data | input | N_REQ*DATA_W | Result data, producer i in bits i*DATA_W +: DATA_W |
| req_tag | input | N_REQ*TAG_W | Source tag, producer i in bits i*TAG_W +: TAG_W |
| req_grant | output | N_REQ | Combinational one-hot grant |
| bus_valid | output | 1 | Registered bus qualifier |
| bus_data | output | DATA_W | Registered broadcast data |
| bus_tag | output | TAG_W | Registered source tag of the producer |
| slot_free | output | N_REQ | Registered one-hot marker of the station released this cycle |

## Verification
The hardest case to reach is the rotation of the round-robin pointer while several producers contend: the pointer has to pass across producers that are idle or carry a zero tag, and it has to wrap from the last index back to 0. The bench first holds all producers pending so that the grant sweeps the whole ring in order. It then mixes in a zero-tag request placed right after the last winner. Finally it runs a long random phase with different arrival rates and random data. A behavioural model built from queued pending requests predicts every grant, bus value and freed station cycle by cycle.

// File: rtl/rbus_pkg.sv
package rbus_pkg;
  localparam int unsigned RBUS_N_REQ_DEF  = 6;
  localparam int unsigned RBUS_DATA_W_DEF = 64;
  localparam int unsigned RBUS_TAG_W_DEF  = 4;
endpackage

// File: rtl/rbus_rr_pick.sv
module rbus_rr_pick #(
  parameter int unsigned N_REQ = 6,
  localparam int unsigned PTR_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic [N_REQ-1:0] elig,
  input  logic [PTR_W-1:0] start,
  output logic [N_REQ-1:0] grant,
  output logic [PTR_W-1:0] win,
  output logic             any
);
  always_comb begin
    grant = '0;
    win   = '0;
    any   = 1'b0;
    for (int k = 0; k < int'(N_REQ); k++) begin
      int idx;
      idx = int'(start) + k;
      if (idx >= int'(N_REQ)) idx = idx - int'(N_REQ);
      if (!any && elig[idx]) begin
        grant[idx] = 1'b1;
        win        = PTR_W'(idx);
        any        = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rbus_out_reg.sv
module rbus_out_reg #(
  parameter int unsigned N_REQ  = 6,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] data_in,
  input  logic [TAG_W-1:0]  tag_in,
  input  logic [N_REQ-1:0]  grant_in,
  output logic              bus_valid,
  output logic [DATA_W-1:0] bus_data,
  output logic [TAG_W-1:0]  bus_tag,
  output logic [N_REQ-1:0]  slot_free
);
  logic [DATA_W-1:0] data_d;
  logic [TAG_W-1:0]  tag_d;

  always_comb begin
    data_d = bus_data;
    tag_d  = bus_tag;
    if (load) begin
      data_d = data_in;
      tag_d  = tag_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_valid <= 1'b0;
      bus_data  <= '0;
      bus_tag   <= '0;
      slot_free <= '0;
    end else begin
      bus_valid <= load;
      bus_data  <= data_d;
      bus_tag   <= tag_d;
      slot_free <= grant_in;
    end
  end
endmodule

// File: rtl/rbus_arbiter.sv
module rbus_arbiter #(
  parameter int unsigned N_REQ  = rbus_pkg::RBUS_N_REQ_DEF,
  parameter int unsigned DATA_W = rbus_pkg::RBUS_DATA_W_DEF,
  parameter int unsigned TAG_W  = rbus_pkg::RBUS_TAG_W_DEF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_REQ-1:0]        req_valid,
  input  logic [N_REQ*DATA_W-1:0] req_data,
  input  logic [N_REQ*TAG_W-1:0]  req_tag,
  output logic [N_REQ-1:0]        req_grant,
  output logic                    bus_valid,
  output logic [DATA_W-1:0]       bus_data,
  output logic [TAG_W-1:0]        bus_tag,
  output logic [N_REQ-1:0]        slot_free
);
  localparam int unsigned PTR_W = (N_REQ > 1) ? $clog2(N_REQ) : 1;
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(N_REQ - 1);

  logic [N_REQ-1:0]  elig;
  logic [PTR_W-1:0]  ptr_q, ptr_d, win;
  logic              any;
  logic [DATA_W-1:0] win_data;
  logic [TAG_W-1:0]  win_tag;

  // a zero tag marks an empty source and is never eligible
  for (genvar i = 0; i < int'(N_REQ); i++) begin : g_elig
    assign elig[i] = req_valid[i] && (req_tag[i*TAG_W +: TAG_W] != '0);
  end

  rbus_rr_pick #(.N_REQ(N_REQ)) pick_i (
    .elig  (elig),
    .start (ptr_q),
    .grant (req_grant),
    .win   (win),
    .any   (any)
  );

  // one-hot AND-OR selection of the winner's payload
  always_comb begin
    win_data = '0;
    win_tag  = '0;
    for (int i = 0; i < int'(N_REQ); i++) begin
      win_data = win_data | ({DATA_W{req_grant[i]}} & req_data[i*DATA_W +: DATA_W]);
      win_tag  = win_tag  | ({TAG_W{req_grant[i]}}  & req_tag[i*TAG_W +: TAG_W]);
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (any) ptr_d = (win == LAST_IDX) ? '0 : win + PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  rbus_out_reg #(.N_REQ(N_REQ), .DATA_W(DATA_W), .TAG_W(TAG_W)) oreg_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (any),
    .data_in   (win_data),
    .tag_in    (win_tag),
    .grant_in  (req_grant),
    .bus_valid (bus_valid),
    .bus_data  (bus_data),
    .bus_tag   (bus_tag),
    .slot_free (slot_free)
  );
endmodule

// File: rtl/rbus_arbiter_chk.sv
module rbus_arbiter_chk #(
  parameter int unsigned N_REQ  = 6,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned TAG_W  = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [N_REQ-1:0]        req_valid,
  input logic [N_REQ*DATA_W-1:0] req_data,
  input logic [N_REQ*TAG_W-1:0]  req_tag,
  input logic [N_REQ-1:0]        req_grant,
  input logic                    bus_valid,
  input logic [DATA_W-1:0]       bus_data,
  input logic [TAG_W-1:0]        bus_tag,
  input logic [N_REQ-1:0]        slot_free
);
  logic [N_REQ-1:0] ok_src;
  logic [DATA_W-1:0] sel_data;
  logic [TAG_W-1:0]  sel_tag;
  always_comb begin
    sel_data = '0;
    sel_tag  = '0;
    for (int i = 0; i < int'(N_REQ); i++) begin
      ok_src[i] = req_valid[i] && (req_tag[i*TAG_W +: TAG_W] != '0);
      if (req_grant[i]) begin
        sel_data = req_data[i*DATA_W +: DATA_W];
        sel_tag  = req_tag[i*TAG_W +: TAG_W];
      end
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !bus_valid && slot_free == '0);
  p_one_grant_r2: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(req_grant));
  p_grant_eligible_r3: assert property (@(posedge clk) disable iff (!rst_n) (req_grant & ~ok_src) == '0);
  p_bus_payload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_grant != '0) |=> bus_valid && bus_data == $past(sel_data) && bus_tag == $past(sel_tag));
  p_idle_bus_r5: assert property (@(posedge clk) disable iff (!rst_n) (req_grant == '0) |=> !bus_valid);
  p_free_follows_r6: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> slot_free == $past(req_grant));
  p_work_conserving_r8: assert property (@(posedge clk) disable iff (!rst_n) (ok_src != '0) |-> (req_grant != '0));
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_grant == '0) |=> $stable(bus_data) && $stable(bus_tag));
  p_tag_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n) bus_valid |-> bus_tag != '0);
endmodule

bind rbus_arbiter rbus_arbiter_chk #(.N_REQ(N_REQ), .DATA_W(DATA_W), .TAG_W(TAG_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_data(req_data), .req_tag(req_tag),
  .req_grant(req_grant), .bus_valid(bus_valid), .bus_data(bus_data), .bus_tag(bus_tag),
  .slot_free(slot_free)
);

// File: tb/rbus_arbiter_tb_top.sv
`timescale 1ns/1ps
module rbus_arbiter_tb_top;
  localparam int N = 6;
  localparam int DW = 64;
  localparam int TW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]    req_valid;
  logic [N*DW-1:0] req_data;
  logic [N*TW-1:0] req_tag;
  logic [N-1:0]    req_grant;
  logic            bus_valid;
  logic [DW-1:0]   bus_data;
  logic [TW-1:0]   bus_tag;
  logic [N-1:0]    slot_free;

  always #2 clk = ~clk;

  rbus_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_data(req_data), .req_tag(req_tag),
    .req_grant(req_grant), .bus_valid(bus_valid), .bus_data(bus_data), .bus_tag(bus_tag),
    .slot_free(slot_free)
  );

  // behavioural producers and model state
  bit          pend [N];
  logic [DW-1:0] pdat [N];
  logic [TW-1:0] ptag [N];
  int          m_ptr;
  bit          e_valid;
  logic [DW-1:0] e_data;
  logic [TW-1:0] e_tag;
  logic [N-1:0]  e_free;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  task automatic drive();
    for (int i = 0; i < N; i++) begin
      req_valid[i] = pend[i];
      req_data[i*DW +: DW] = pdat[i];
      req_tag[i*TW +: TW] = ptag[i];
    end
  endtask

  function automatic int pick();
    for (int k = 0; k < N; k++) begin
      int idx = (m_ptr + k) % N;
      if (pend[idx] && ptag[idx] != 0) return idx;
    end
    return -1;
  endfunction

  task automatic chk(bit ok, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  // one cycle: check grant at negedge, check bus after the edge, update model
  task automatic step();
    int g;
    logic [N-1:0] eg;
    drive();
    @(negedge clk);
    g = pick();
    eg = (g >= 0) ? N'(1) << g : '0;
    chk(req_grant == eg, "R2 R3 R7 R8 grant", 128'(req_grant), 128'(eg));
    @(posedge clk);
    #1;
    if (g >= 0) begin
      e_valid = 1; e_data = pdat[g]; e_tag = ptag[g];
      m_ptr = (g + 1) % N;
      pend[g] = 0;
    end else e_valid = 0;
    e_free = eg;
    chk(bus_valid == e_valid, "R4 R5 bus_valid", 128'(bus_valid), 128'(e_valid));
    chk(bus_data == e_data, "R4 R9 bus_data", 128'(bus_data), 128'(e_data));
    chk(bus_tag == e_tag, "R4 R9 R10 bus_tag", 128'(bus_tag), 128'(e_tag));
    chk(slot_free == e_free, "R6 slot_free", 128'(slot_free), 128'(e_free));
  endtask

  task automatic post(int i, logic [TW-1:0] t);
    pend[i] = 1; ptag[i] = t; pdat[i] = {$urandom, $urandom};
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin pend[i] = 0; pdat[i] = '0; ptag[i] = '0; end
    m_ptr = 0; e_valid = 0; e_data = '0; e_tag = '0; e_free = '0;
    drive();
    repeat (3) @(posedge clk);
    #1;
    chk(bus_valid == 0 && bus_tag == 0 && slot_free == 0, "R1 reset outputs",
        128'({bus_valid, bus_tag, slot_free}), 128'(0));
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(bus_valid == 0 && slot_free == 0, "R1 first cycle", 128'({bus_valid, slot_free}), 128'(0));

    // single producer
    post(3, 4'd9);
    repeat (3) step();

    // all producers at once: full sweep of the ring, wrap included (R7)
    for (int i = 0; i < N; i++) post(i, TW'(i + 1));
    repeat (N + 2) step();

    // zero tag right after the last winner is skipped (R3)
    post(1, 4'd0);
    repeat (2) step();
    post(4, 4'd7); post(0, 4'd5);
    repeat (3) step();
    pend[1] = 0;
    step();

    // random traffic with several arrival rates
    for (int phase = 0; phase < 3; phase++) begin
      for (int c = 0; c < 1500; c++) begin
        for (int i = 0; i < N; i++)
          if (!pend[i] && ($urandom % 8) < (phase * 3 + 1))
            post(i, TW'(($urandom % 15) + 1));
        step();
      end
    end
    repeat (N + 2) step();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule